// File: doc/BRIEF.md
# Shared Bus Register Transfer Datapath

This block is the data side of a small accumulator machine. Six working registers of 12 or 16 bits, an 8-bit character output register, an 8-bit character input register and a 4096-word by 16-bit memory all meet on one 16-bit internal bus. In each cycle a 3-bit select code picks at most one source to drive the bus. Any set of destinations then captures the bus value on the next rising clock edge. Each destination has its own load, increment and clear strobes.

Memory is reached only through the address register. A read puts the addressed word on the bus and a write stores the data register at that address. Characters arrive through the input register. A pack strobe shifts the low byte of the accumulator up and brings the input character in underneath. Instruction decoding and sequencing are not part of the block: every strobe comes straight from the surrounding controller, or from the bench.

Top module: `rt_bus_datapath`

## Requirements
- R1: While reset is active, and right after it, every register reads zero. This covers address, program counter, data, accumulator, instruction, temporary, input and output.
- R2: Select codes are 0 none, 1 address, 2 program counter, 3 data, 4 accumulator, 5 instruction, 6 temporary, 7 memory. The bus carries the chosen source in the same cycle. A 12-bit source is zero-extended to 16 bits.
- R3: A destination whose load bit is set captures the bus on the next rising edge. The strobe vectors use bit 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temporary, 6 output. A 12-bit destination takes bus bits 11:0 and the output register takes bits 7:0.
- R4: A transfer leaves its source register unchanged.
- R5: A register with no strobe set keeps its value.
- R6: Several destinations with their load bits set in the same cycle all capture the same bus value on the same edge.
- R7: An increment strobe adds one, wrapping modulo the register width. The program counter goes from 0xFFF to 0x000.
- R8: Per register, clear wins over load, and load wins over increment.
- R9: With code 7 and the read strobe set, the bus carries the memory word at the address register. With code 7 and no read strobe, the bus is zero. The write strobe stores the data register at the address register's location on the rising edge. A write and a memory-sourced read must not fall in the same cycle.
- R10: The input register takes the character input on an edge with its load strobe set and otherwise holds. The pack strobe sets the accumulator to {accumulator bits 7:0, input register}, and clear beats pack.
- R11: Code 0 drives zero onto the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source select code |
| ld_en | input | 7 | Per-destination load strobes |
| inc_en | input | 7 | Per-destination increment strobes |
| clr_en | input | 7 | Per-destination clear strobes |
| mem_rd | input | 1 | Memory read enable for code 7 |
| mem_wr | input | 1 | Memory write of data register at address register |
| in_char | input | 8 | External character input |
| in_ld | input | 1 | Input register load strobe |
| in_xfer | input | 1 | Pack input character into accumulator |
| bus_val | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| in_q | output | 8 | Input register |
| out_char | output | 8 | Output register (character output) |

## Verification
The bus value is combinational, so it is due in the same cycle its select and read strobe are applied. The bench samples it two nanoseconds after driving inputs on the falling edge. Register, memory and input-register results are due one rising edge later, and the bench samples them two nanoseconds after that edge, before the next falling edge drives new inputs. Memory contents become visible only through a later read with code 7, one cycle after the write edge at the earliest. Reset clears the registers asynchronously, so those values are checked while reset is still held.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_ADDR = 3'd1,
      SRC_PC   = 3'd2,
      SRC_DATA = 3'd3,
      SRC_ACC  = 3'd4,
      SRC_INSN = 3'd5,
      SRC_TEMP = 3'd6,
      SRC_MEM  = 3'd7
   } src_sel_e;

   // Destination strobe bit positions; the first six also equal (code - 1).
   localparam int DST_ADDR = 0;
   localparam int DST_PC   = 1;
   localparam int DST_DATA = 2;
   localparam int DST_ACC  = 3;
   localparam int DST_INSN = 4;
   localparam int DST_TEMP = 5;
   localparam int DST_OUT  = 6;
   localparam int NUM_SRC  = 6;
   localparam int NUM_DST  = 7;
endpackage

// File: rtl/rtb_reg.sv
module rtb_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         alt_ld,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] d,
   input  logic [W-1:0] alt_d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("rtb_reg: width must be positive");
   end

   logic [W-1:0] q_nxt;

   // Priority: clear, alternate load, bus load, increment, hold.
   always_comb begin
      if (clr)         q_nxt = '0;
      else if (alt_ld) q_nxt = alt_d;
      else if (ld)     q_nxt = d;
      else if (inc)    q_nxt = q + W'(1);
      else             q_nxt = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/rtb_mem.sv
module rtb_mem #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_bad_depth
      $error("rtb_mem: address width above 12 gives an oversized array");
   end

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) words[addr] <= wdata;
   end

   assign rdata = words[addr];
endmodule

// File: rtl/rtb_bus_mux.sv
module rtb_bus_mux
   import rtb_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  src_sel_e                        sel,
   input  logic [NUM_SRC-1:0][DATA_W-1:0]  regs,
   input  logic [DATA_W-1:0]               mem_word,
   input  logic                            mem_rd,
   output logic [DATA_W-1:0]               bus
);
   always_comb begin
      unique case (sel)
         SRC_NONE: bus = '0;
         SRC_MEM:  bus = mem_rd ? mem_word : '0;
         default:  bus = regs[int'(sel) - 1];
      endcase
   end
endmodule

// File: rtl/rt_bus_datapath.sv
module rt_bus_datapath
   import rtb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int CHAR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         bus_sel,
   input  logic [6:0]         ld_en,
   input  logic [6:0]         inc_en,
   input  logic [6:0]         clr_en,
   input  logic               mem_rd,
   input  logic               mem_wr,
   input  logic [CHAR_W-1:0]  in_char,
   input  logic               in_ld,
   input  logic               in_xfer,
   output logic [DATA_W-1:0]  bus_val,
   output logic [ADDR_W-1:0]  ar_q,
   output logic [ADDR_W-1:0]  pc_q,
   output logic [DATA_W-1:0]  dr_q,
   output logic [DATA_W-1:0]  ac_q,
   output logic [DATA_W-1:0]  ir_q,
   output logic [DATA_W-1:0]  tr_q,
   output logic [CHAR_W-1:0]  in_q,
   output logic [CHAR_W-1:0]  out_char
);
   localparam int PACK_W = DATA_W - CHAR_W;

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("rt_bus_datapath: address register wider than bus");
   end
   if (CHAR_W >= DATA_W) begin : g_bad_char
      $error("rt_bus_datapath: character must be narrower than bus");
   end

   logic [NUM_SRC-1:0][DATA_W-1:0] src_ext;
   logic [DATA_W-1:0]              mem_word;

   // Six bus-source registers; width chosen per index.
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int W = (i == DST_ADDR || i == DST_PC) ? ADDR_W : DATA_W;
      logic [W-1:0] q;
      logic [W-1:0] alt_d;
      logic         alt_ld;

      if (i == DST_ACC) begin : g_pack
         assign alt_ld = in_xfer;
         assign alt_d  = {q[PACK_W-1:0], in_q};
      end else begin : g_nopack
         assign alt_ld = 1'b0;
         assign alt_d  = '0;
      end

      rtb_reg #(.W(W)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr_en[i]),
         .alt_ld (alt_ld),
         .ld     (ld_en[i]),
         .inc    (inc_en[i]),
         .d      (bus_val[W-1:0]),
         .alt_d  (alt_d),
         .q      (q)
      );

      assign src_ext[i] = DATA_W'(q);
   end

   rtb_reg #(.W(CHAR_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_en[DST_OUT]),
      .alt_ld (1'b0),
      .ld     (ld_en[DST_OUT]),
      .inc    (inc_en[DST_OUT]),
      .d      (bus_val[CHAR_W-1:0]),
      .alt_d  ('0),
      .q      (out_char)
   );

   rtb_reg #(.W(CHAR_W)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .alt_ld (1'b0),
      .ld     (in_ld),
      .inc    (1'b0),
      .d      (in_char),
      .alt_d  ('0),
      .q      (in_q)
   );

   rtb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .wr    (mem_wr),
      .addr  (ar_q),
      .wdata (dr_q),
      .rdata (mem_word)
   );

   rtb_bus_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (src_sel_e'(bus_sel)),
      .regs     (src_ext),
      .mem_word (mem_word),
      .mem_rd   (mem_rd),
      .bus      (bus_val)
   );

   assign ar_q = g_src[DST_ADDR].q;
   assign pc_q = g_src[DST_PC].q;
   assign dr_q = g_src[DST_DATA].q;
   assign ac_q = g_src[DST_ACC].q;
   assign ir_q = g_src[DST_INSN].q;
   assign tr_q = g_src[DST_TEMP].q;
endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int CHAR_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         bus_sel,
   input logic [6:0]         ld_en,
   input logic [6:0]         inc_en,
   input logic [6:0]         clr_en,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               in_ld,
   input logic               in_xfer,
   input logic [DATA_W-1:0]  bus_val,
   input logic [ADDR_W-1:0]  ar_q,
   input logic [ADDR_W-1:0]  pc_q,
   input logic [DATA_W-1:0]  ac_q,
   input logic [CHAR_W-1:0]  in_q,
   input logic [CHAR_W-1:0]  out_char
);
   AST_SEL_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel == 3'd0 |-> bus_val == '0); // R11
   AST_ADDR_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel == 3'd1 |-> bus_val[DATA_W-1:ADDR_W] == '0); // R2
   AST_AR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en[0] && !clr_en[0] |=> ar_q == $past(bus_val[ADDR_W-1:0])); // R3
   AST_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en[6] && !clr_en[6] |=> out_char == $past(bus_val[CHAR_W-1:0])); // R3
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en[1] || inc_en[1] || clr_en[1]) |=> $stable(pc_q)); // R5
   AST_AC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en[3] || inc_en[3] || clr_en[3] || in_xfer) |=> $stable(ac_q)); // R4
   AST_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en[1] && !ld_en[1] && !clr_en[1] |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R7
   AST_AC_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en[3] |=> ac_q == '0); // R8
   AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel == 3'd7 && !mem_rd |-> bus_val == '0); // R9
   AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd && bus_sel == 3'd7)); // R9
   AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ld |=> $stable(in_q)); // R10
endmodule

bind rt_bus_datapath rtb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/sim_rt_bus_datapath.sv
module sim_rt_bus_datapath;
   typedef struct packed {
      logic [2:0]  sel;
      logic [6:0]  ld;
      logic [6:0]  inc;
      logic [6:0]  clr;
      logic        rd;
      logic        wr;
      logic [15:0] bus;
      logic [2:0]  ra;
      logic [15:0] va;
      logic [2:0]  rb;
      logic [15:0] vb;
      logic [3:0]  req;
   } vec_t;

   // Register index for ra/rb: 0 addr, 1 pc, 2 data, 3 acc, 4 insn, 5 temp, 6 out, 7 in.
   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{3'd4, 7'h65, 7'h00, 7'h00, 1'b0, 1'b0, 16'h12F4, 3'd0, 16'h02F4, 3'd6, 16'h00F4, 4'd3},  // R3 multi load, truncation
      '{3'd4, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 16'h12F4, 3'd3, 16'h12F4, 3'd5, 16'h12F4, 4'd6},  // R4 source kept, R6 same edge
      '{3'd1, 7'h02, 7'h00, 7'h00, 1'b0, 1'b0, 16'h02F4, 3'd1, 16'h02F4, 3'd0, 16'h02F4, 4'd2},  // R2 zero-extend
      '{3'd0, 7'h20, 7'h00, 7'h00, 1'b0, 1'b0, 16'h0000, 3'd5, 16'h0000, 3'd2, 16'h12F4, 4'd11}, // R11 none drives zero
      '{3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b1, 16'h0000, 3'd2, 16'h12F4, 3'd0, 16'h02F4, 4'd9},  // R9 write 0x2F4
      '{3'd0, 7'h00, 7'h08, 7'h00, 1'b0, 1'b0, 16'h0000, 3'd3, 16'h12F5, 3'd1, 16'h02F4, 4'd7},  // R7 acc inc
      '{3'd4, 7'h04, 7'h00, 7'h00, 1'b0, 1'b0, 16'h12F5, 3'd2, 16'h12F5, 3'd3, 16'h12F5, 4'd3},  // R3
      '{3'd0, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0, 16'h0000, 3'd0, 16'h02F5, 3'd2, 16'h12F5, 4'd7},  // R7 addr inc
      '{3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b1, 16'h0000, 3'd0, 16'h02F5, 3'd2, 16'h12F5, 4'd9},  // R9 write 0x2F5
      '{3'd7, 7'h10, 7'h00, 7'h00, 1'b1, 1'b0, 16'h12F5, 3'd4, 16'h12F5, 3'd0, 16'h02F5, 4'd9},  // R9 read 0x2F5
      '{3'd2, 7'h01, 7'h00, 7'h00, 1'b0, 1'b0, 16'h02F4, 3'd0, 16'h02F4, 3'd1, 16'h02F4, 4'd3},  // R3
      '{3'd7, 7'h04, 7'h00, 7'h00, 1'b1, 1'b0, 16'h12F4, 3'd2, 16'h12F4, 3'd4, 16'h12F5, 4'd9},  // R9 read 0x2F4
      '{3'd7, 7'h08, 7'h00, 7'h00, 1'b0, 1'b0, 16'h0000, 3'd3, 16'h0000, 3'd2, 16'h12F4, 4'd9},  // R9 gated read
      '{3'd5, 7'h08, 7'h00, 7'h00, 1'b0, 1'b0, 16'h12F5, 3'd3, 16'h12F5, 3'd4, 16'h12F5, 4'd3},  // R3
      '{3'd3, 7'h08, 7'h08, 7'h08, 1'b0, 1'b0, 16'h12F4, 3'd3, 16'h0000, 3'd2, 16'h12F4, 4'd8},  // R8 clear wins
      '{3'd3, 7'h08, 7'h08, 7'h00, 1'b0, 1'b0, 16'h12F4, 3'd3, 16'h12F4, 3'd2, 16'h12F4, 4'd8},  // R8 load beats inc
      '{3'd6, 7'h00, 7'h40, 7'h00, 1'b0, 1'b0, 16'h0000, 3'd6, 16'h00F5, 3'd5, 16'h0000, 4'd7},  // R7 out inc
      '{3'd6, 7'h02, 7'h00, 7'h01, 1'b0, 1'b0, 16'h0000, 3'd0, 16'h0000, 3'd1, 16'h0000, 4'd8}   // R8 clear, R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_sel = '0;
   logic [6:0]  ld_en = '0, inc_en = '0, clr_en = '0;
   logic        mem_rd = 1'b0, mem_wr = 1'b0;
   logic [7:0]  in_char = '0;
   logic        in_ld = 1'b0, in_xfer = 1'b0;
   logic [15:0] bus_val, dr_q, ac_q, ir_q, tr_q;
   logic [11:0] ar_q, pc_q;
   logic [7:0]  in_q, out_char;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rt_bus_datapath u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ld_en(ld_en), .inc_en(inc_en),
      .clr_en(clr_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .in_char(in_char),
      .in_ld(in_ld), .in_xfer(in_xfer), .bus_val(bus_val), .ar_q(ar_q), .pc_q(pc_q),
      .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q), .in_q(in_q), .out_char(out_char)
   );

   function automatic logic [15:0] reg_val(input logic [2:0] idx);
      case (idx)
         3'd0:    return {4'h0, ar_q};
         3'd1:    return {4'h0, pc_q};
         3'd2:    return dr_q;
         3'd3:    return ac_q;
         3'd4:    return ir_q;
         3'd5:    return tr_q;
         3'd6:    return {8'h00, out_char};
         default: return {8'h00, in_q};
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] sel, input logic [6:0] ld, input logic [6:0] inc,
                        input logic [6:0] clr, input logic rd, input logic wr,
                        input logic inl, input logic xf, input logic [7:0] ch);
      @(negedge clk);
      bus_sel = sel; ld_en = ld; inc_en = inc; clr_en = clr;
      mem_rd = rd; mem_wr = wr; in_ld = inl; in_xfer = xf; in_char = ch;
      #2;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check_all(input string req, input logic [15:0] e [8]);
      for (int k = 0; k < 8; k++) chk(req, reg_val(3'(k)), e[k]);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] e [8];
      repeat (3) @(posedge clk);
      #2;
      // R1: registers zero while reset held
      for (int k = 0; k < 8; k++) e[k] = '0;
      check_all("R1", e);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check_all("R1", e);

      // R10: input register load and packing
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12); tick();
      chk("R10", reg_val(3'd7), 16'h0012);
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); tick();
      chk("R10", reg_val(3'd3), 16'h0012);
      chk("R10", reg_val(3'd7), 16'h0012);
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF4); tick();
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); tick();
      chk("R10", reg_val(3'd3), 16'h12F4);

      // Table walk: bus in the drive cycle, registers after the edge
      for (int v = 0; v < NV; v++) begin
         if (VEC[v].wr && VEC[v].rd && VEC[v].sel == 3'd7) begin
            n_fail++;
            $display("FAIL R9: actual read+write collision expected none (row %0d)", v);
         end
         drive(VEC[v].sel, VEC[v].ld, VEC[v].inc, VEC[v].clr, VEC[v].rd, VEC[v].wr,
               1'b0, 1'b0, 8'h00);
         chk($sformatf("R%0d bus row %0d", VEC[v].req, v), bus_val, VEC[v].bus);
         tick();
         chk($sformatf("R%0d row %0d", VEC[v].req, v), reg_val(VEC[v].ra), VEC[v].va);
         chk($sformatf("R%0d row %0d", VEC[v].req, v), reg_val(VEC[v].rb), VEC[v].vb);
      end

      // R5 and R10: idle cycle with a new character but no load strobe
      drive(3'd4, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77); tick();
      e = '{16'h0000, 16'h0000, 16'h12F4, 16'h12F4, 16'h12F5, 16'h0000, 16'h00F5, 16'h00F4};
      check_all("R5", e);

      // R7: program counter wraps from 0xFFF
      drive(3'd0, 7'h00, 7'h00, 7'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F); tick();
      chk("R8", reg_val(3'd3), 16'h0000);
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); tick();
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF); tick();
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00); tick();
      chk("R10", reg_val(3'd3), 16'h0FFF);
      drive(3'd4, 7'h02, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); tick();
      chk("R7", reg_val(3'd1), 16'h0FFF);
      drive(3'd0, 7'h00, 7'h02, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); tick();
      chk("R7", reg_val(3'd1), 16'h0000);
      chk("R7", reg_val(3'd3), 16'h0FFF);

      // R1: reset in mid-run clears everything
      drive(3'd0, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      rst_n = 1'b0;
      #2;
      for (int k = 0; k < 8; k++) e[k] = '0;
      check_all("R1", e);
      tick();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      check_all("R1", e);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule